// File: doc/BRIEF.md
# Audio Sample FIFO Pair with Threshold Service Requests

This block sits between a DMA-driven system bus and a serial audio port. It holds two independent queues. The transmit queue accepts 16-bit signed samples from the bus and hands them to the serial transmitter. The receive queue takes samples from the serial receiver and hands them back to the bus. Each direction raises a service request line for the DMA engine. The point at which that line asserts is set by a per-direction threshold.

Thresholds are given as the wanted sample count minus one. Each direction clamps its threshold to its own parameterised maximum. A mode input chooses between per-sample operation and burst operation. In per-sample operation the threshold is ignored and a request means "one sample can be moved". In burst operation a request means "a threshold-sized burst can be moved".

The transmit request is sticky. Once it is raised, it stays raised until the queue is completely full. This way a playback start always primes the whole buffer. Each transmit entry is 32 bits wide and holds the sign-extended sample. Status outputs report each queue's fill level, full, empty, a sticky transmit underrun and a sticky receive overrun. A synchronous clear input per direction empties one queue and drops its flag without touching the other queue.

Top module: `audio_dma_fifo`

## Requirements
- R1: After reset, each queue has level 0, empty=1, full=0 and its sticky flag at 0. A clear pulse on one direction restores that state for that direction one cycle later and leaves the other direction's level unchanged.
- R2: Each queue holds DEPTH entries and returns samples in the order they were written. The level goes up by one per accepted write and down by one per read, and full asserts exactly when the level equals DEPTH.
- R3: A bus write to a full transmit queue is discarded. The level stays at DEPTH and the queued contents are unchanged.
- R4: The serial transmit word is the head sample sign-extended from bit 15 to ENTRY_W bits. The bus receive word is the head sample as pushed.
- R5: A serial pop from an empty transmit queue drives an all-zero transmit word, leaves the level at 0 and sets the underrun flag. The flag stays set until a transmit clear.
- R6: A serial push into a full receive queue is discarded and sets the overrun flag. The flag stays set until a receive clear.
- R7: In burst mode (mode=1) with effective receive threshold t, the receive request is 1 exactly when the receive level is at least t+1.
- R8: In burst mode with effective transmit threshold t, the transmit request asserts when the free space is at least t+1. Once asserted, it stays at 1 until the queue becomes full. While full, it is 0.
- R9: In per-sample mode (mode=0) both threshold inputs are ignored. The receive request equals "not empty". The transmit request asserts whenever at least one entry is free and then holds until full.
- R10: A threshold input above the direction's maximum (TX_THR_MAX or RX_THR_MAX) acts as that maximum.
- R11: A bus read of an empty receive queue returns zero, leaves the level at 0 and does not change the overrun flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| txClr | input | 1 | Synchronous clear of the transmit queue |
| rxClr | input | 1 | Synchronous clear of the receive queue |
| thrMode | input | 1 | 1 = burst (threshold) mode, 0 = per-sample mode |
| txThr | input | $clog2(DEPTH) | Transmit threshold, sample count minus one |
| rxThr | input | $clog2(DEPTH) | Receive threshold, sample count minus one |
| busTxWr | input | 1 | Bus writes one sample to the transmit queue |
| busTxData | input | SAMPLE_W | Sample written by the bus |
| busRxRd | input | 1 | Bus reads one sample from the receive queue |
| busRxData | output | SAMPLE_W | Receive head sample, zero when empty |
| serTxPop | input | 1 | Serial side takes one transmit word |
| serTxData | output | ENTRY_W | Transmit head word, sign-extended, zero when empty |
| serRxPush | input | 1 | Serial side delivers one received sample |
| serRxData | input | SAMPLE_W | Sample delivered by the serial side |
| txReq | output | 1 | Transmit service request |
| rxReq | output | 1 | Receive service request |
| txLevel | output | $clog2(DEPTH+1) | Transmit fill level |
| rxLevel | output | $clog2(DEPTH+1) | Receive fill level |
| txFull | output | 1 | Transmit queue full |
| txEmpty | output | 1 | Transmit queue empty |
| rxFull | output | 1 | Receive queue full |
| rxEmpty | output | 1 | Receive queue empty |
| txUnderrun | output | 1 | Sticky transmit underrun flag |
| rxOverrun | output | 1 | Sticky receive overrun flag |

## Verification
A level counter that drifts from the pointers shows up at the ports within one cycle: either the level output is wrong or the head word is wrong on the next pop. A miscounted level also moves the request edge by one sample, and the threshold sweeps check that edge at every fill level. A lost transmit hold bit shows on the cycle after the free space drops below the threshold on a refill. A pointer that wraps wrongly first shows on the DEPTH+1-th transfer, when the head word comes out of order.

// File: rtl/afifo_pkg.sv
package afifo_pkg;
  // strobes sent by a queue controller to its storage datapath
  typedef struct packed {
    logic clr;
    logic push;
    logic pop;
  } fifoStrobe_t;
endpackage

// File: rtl/afifo_store.sv
module afifo_store
  import afifo_pkg::*;
#(
  parameter int DEPTH   = 1024,
  parameter int ENTRY_W = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  fifoStrobe_t        stb,
  input  logic [ENTRY_W-1:0] wrData,
  output logic [ENTRY_W-1:0] headData
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [ENTRY_W-1:0] mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else if (stb.clr) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (stb.push) wrPtr <= bump(wrPtr);
      if (stb.pop)  rdPtr <= bump(rdPtr);
    end
  end

  always_ff @(posedge clk) begin
    if (stb.push) mem[wrPtr] <= wrData;
  end

  assign headData = mem[rdPtr];

  // R2
  ptr_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrPtr <= LAST) && (rdPtr <= LAST));
endmodule

// File: rtl/afifo_ctrl.sv
module afifo_ctrl
  import afifo_pkg::*;
#(
  parameter int DEPTH   = 1024,
  parameter int THR_MAX = DEPTH - 1,
  parameter bit IS_TX   = 1'b1,
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int THR_W  = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clr,
  input  logic             wrReq,
  input  logic             rdReq,
  input  logic             thrMode,
  input  logic [THR_W-1:0] thr,
  output fifoStrobe_t      stb,
  output logic [CNT_W-1:0] level,
  output logic             full,
  output logic             empty,
  output logic             req,
  output logic             errFlag
);
  localparam logic [THR_W-1:0] THR_CAP = THR_W'(THR_MAX);
  localparam logic [CNT_W-1:0] CAP     = CNT_W'(DEPTH);

  logic [CNT_W-1:0] levelQ;
  logic [CNT_W-1:0] freeSlots;
  logic [CNT_W-1:0] need;
  logic [THR_W-1:0] thrEff;
  logic             errQ;
  logic             errEvent;

  assign full      = (levelQ == CAP);
  assign empty     = (levelQ == '0);
  assign freeSlots = CAP - levelQ;

  always_comb begin
    if (!thrMode)          thrEff = '0;
    else if (thr > THR_CAP) thrEff = THR_CAP;
    else                   thrEff = thr;
  end
  assign need = CNT_W'(thrEff) + CNT_W'(1);

  assign stb.clr  = clr;
  assign stb.push = wrReq & ~full & ~clr;
  assign stb.pop  = rdReq & ~empty & ~clr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      levelQ <= '0;
    end else if (clr) begin
      levelQ <= '0;
    end else begin
      case ({stb.push, stb.pop})
        2'b10:   levelQ <= levelQ + CNT_W'(1);
        2'b01:   levelQ <= levelQ - CNT_W'(1);
        default: levelQ <= levelQ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      errQ <= 1'b0;
    else if (clr)   errQ <= 1'b0;
    else if (errEvent) errQ <= 1'b1;
  end

  generate
    if (IS_TX) begin : g_txReq
      logic armQ;
      assign errEvent = rdReq & empty;
      assign req      = ~full & (armQ | (freeSlots >= need));
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)     armQ <= 1'b0;
        else if (clr)  armQ <= 1'b0;
        else if (full) armQ <= 1'b0;
        else           armQ <= req;
      end
      // R8
      tx_req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
        (req && !clr) |=> (req || full));
    end else begin : g_rxReq
      assign errEvent = wrReq & full;
      assign req      = (levelQ >= need);
    end
  endgenerate

  assign level   = levelQ;
  assign errFlag = errQ;

  // R2
  level_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    levelQ <= CAP);
  // R2
  level_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(clr) |-> (levelQ == $past(levelQ)) ||
                    (levelQ == $past(levelQ) + CNT_W'(1)) ||
                    (levelQ == $past(levelQ) - CNT_W'(1)));
  // R1
  clear_state_chk: assert property (@(posedge clk) disable iff (!rstN)
    clr |=> (levelQ == '0) && !errQ);
  // R5
  sticky_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (errQ && !clr) |=> errQ);
endmodule

// File: rtl/audio_dma_fifo.sv
module audio_dma_fifo
  import afifo_pkg::*;
#(
  parameter int DEPTH      = 1024,
  parameter int SAMPLE_W   = 16,
  parameter int ENTRY_W    = 32,
  parameter int TX_THR_MAX = DEPTH - 1,
  parameter int RX_THR_MAX = DEPTH - 1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       txClr,
  input  logic                       rxClr,
  input  logic                       thrMode,
  input  logic [$clog2(DEPTH)-1:0]   txThr,
  input  logic [$clog2(DEPTH)-1:0]   rxThr,
  input  logic                       busTxWr,
  input  logic [SAMPLE_W-1:0]        busTxData,
  input  logic                       busRxRd,
  output logic [SAMPLE_W-1:0]        busRxData,
  input  logic                       serTxPop,
  output logic [ENTRY_W-1:0]         serTxData,
  input  logic                       serRxPush,
  input  logic [SAMPLE_W-1:0]        serRxData,
  output logic                       txReq,
  output logic                       rxReq,
  output logic [$clog2(DEPTH+1)-1:0] txLevel,
  output logic [$clog2(DEPTH+1)-1:0] rxLevel,
  output logic                       txFull,
  output logic                       txEmpty,
  output logic                       rxFull,
  output logic                       rxEmpty,
  output logic                       txUnderrun,
  output logic                       rxOverrun
);
  localparam int EXT_W = ENTRY_W - SAMPLE_W;

  fifoStrobe_t txStb, rxStb;
  logic [ENTRY_W-1:0]  txWord, txHead;
  logic [SAMPLE_W-1:0] rxHead;

  assign txWord = {{EXT_W{busTxData[SAMPLE_W-1]}}, busTxData};

  afifo_ctrl #(.DEPTH(DEPTH), .THR_MAX(TX_THR_MAX), .IS_TX(1'b1)) i_txCtrl (
    .clk(clk), .rstN(rstN), .clr(txClr), .wrReq(busTxWr), .rdReq(serTxPop),
    .thrMode(thrMode), .thr(txThr), .stb(txStb), .level(txLevel),
    .full(txFull), .empty(txEmpty), .req(txReq), .errFlag(txUnderrun));

  afifo_store #(.DEPTH(DEPTH), .ENTRY_W(ENTRY_W)) i_txStore (
    .clk(clk), .rstN(rstN), .stb(txStb), .wrData(txWord), .headData(txHead));

  afifo_ctrl #(.DEPTH(DEPTH), .THR_MAX(RX_THR_MAX), .IS_TX(1'b0)) i_rxCtrl (
    .clk(clk), .rstN(rstN), .clr(rxClr), .wrReq(serRxPush), .rdReq(busRxRd),
    .thrMode(thrMode), .thr(rxThr), .stb(rxStb), .level(rxLevel),
    .full(rxFull), .empty(rxEmpty), .req(rxReq), .errFlag(rxOverrun));

  afifo_store #(.DEPTH(DEPTH), .ENTRY_W(SAMPLE_W)) i_rxStore (
    .clk(clk), .rstN(rstN), .stb(rxStb), .wrData(serRxData), .headData(rxHead));

  assign serTxData = txEmpty ? '0 : txHead;
  assign busRxData = rxEmpty ? '0 : rxHead;
endmodule

// File: tb/test_audio_dma_fifo.sv
`timescale 1ns/1ps
module test_audio_dma_fifo;
  localparam int D = 16;
  localparam int TXMAX = 11;
  localparam int RXMAX = 13;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic txClr = 0, rxClr = 0, thrMode = 1;
  logic [3:0] txThr = 0, rxThr = 0;
  logic busTxWr = 0, busRxRd = 0, serTxPop = 0, serRxPush = 0;
  logic [15:0] busTxData = 0, serRxData = 0;
  logic [15:0] busRxData;
  logic [31:0] serTxData;
  logic txReq, rxReq, txFull, txEmpty, rxFull, rxEmpty, txUnderrun, rxOverrun;
  logic [4:0] txLevel, rxLevel;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  audio_dma_fifo #(.DEPTH(D), .TX_THR_MAX(TXMAX), .RX_THR_MAX(RXMAX)) i_audio_dma_fifo (
    .clk(clk), .rstN(rstN), .txClr(txClr), .rxClr(rxClr), .thrMode(thrMode),
    .txThr(txThr), .rxThr(rxThr), .busTxWr(busTxWr), .busTxData(busTxData),
    .busRxRd(busRxRd), .busRxData(busRxData), .serTxPop(serTxPop),
    .serTxData(serTxData), .serRxPush(serRxPush), .serRxData(serRxData),
    .txReq(txReq), .rxReq(rxReq), .txLevel(txLevel), .rxLevel(rxLevel),
    .txFull(txFull), .txEmpty(txEmpty), .rxFull(rxFull), .rxEmpty(rxEmpty),
    .txUnderrun(txUnderrun), .rxOverrun(rxOverrun));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive one cycle of strobes starting at a falling edge
  task automatic step(input bit tw, input bit tp, input bit rw, input bit rr,
                      input bit tc, input bit rc, input logic [15:0] td, input logic [15:0] rd);
    busTxWr = tw; serTxPop = tp; serRxPush = rw; busRxRd = rr;
    txClr = tc; rxClr = rc; busTxData = td; serRxData = rd;
    @(negedge clk);
    busTxWr = 0; serTxPop = 0; serRxPush = 0; busRxRd = 0; txClr = 0; rxClr = 0;
  endtask

  function automatic logic [15:0] txPat(input int i, input int t);
    return 16'((i * 4099 + t * 17) ^ ((i % 2 == 1) ? 32'h8000 : 32'h0));
  endfunction

  function automatic logic [15:0] rxPat(input int i, input int t);
    return 16'(i * 3001 + t * 257 + 5);
  endfunction

  initial begin
    #(200000 * 5);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(txLevel == 0 && txEmpty && !txFull && !txUnderrun, "R1 tx reset", txLevel, 0);
    chk(rxLevel == 0 && rxEmpty && !rxFull && !rxOverrun, "R1 rx reset", rxLevel, 0);
    chk(rxReq == 0, "R7 rx req at reset", rxReq, 0);

    // transmit sweep over every threshold value
    for (int t = 0; t < D; t++) begin
      int need;
      need = ((t > TXMAX) ? TXMAX : t) + 1;
      thrMode = 1; txThr = 4'(t);
      step(0,0,0,0,1,0,0,0);
      chk(txReq == 1, "R8 empty tx req", txReq, 1);
      for (int i = 0; i < D; i++) begin
        step(1,0,0,0,0,0,txPat(i,t),0);
        chk(txLevel == 5'(i+1), "R2 tx level fill", txLevel, i+1);
        chk(txReq == (i+1 < D), "R8 tx req held until full", txReq, (i+1 < D));
      end
      chk(txFull == 1, "R2 tx full", txFull, 1);
      step(1,0,0,0,0,0,16'hDEAD,0);
      chk(txLevel == 5'(D), "R3 write to full ignored", txLevel, D);
      for (int k = 1; k <= D; k++) begin
        logic [31:0] e;
        e = {{16{txPat(k-1,t)[15]}}, txPat(k-1,t)};
        chk(serTxData == e, "R4 R2 tx word order and sign", serTxData, e);
        step(0,1,0,0,0,0,0,0);
        chk(txLevel == 5'(D-k), "R2 tx level drain", txLevel, D-k);
        chk(txReq == (k >= need), (t > TXMAX) ? "R10 tx clamp" : "R8 tx req on free space",
            txReq, (k >= need));
      end
      chk(serTxData == 0, "R5 empty tx word zero", serTxData, 0);
      step(0,1,0,0,0,0,0,0);
      chk(txUnderrun == 1 && txLevel == 0, "R5 underrun set", txUnderrun, 1);
      step(0,0,0,0,0,0,0,0);
      chk(txUnderrun == 1, "R5 underrun sticky", txUnderrun, 1);
      step(0,0,0,0,1,0,0,0);
      chk(txUnderrun == 0, "R1 tx clear drops flag", txUnderrun, 0);
    end

    // receive sweep over every threshold value
    for (int t = 0; t < D; t++) begin
      int need;
      need = ((t > RXMAX) ? RXMAX : t) + 1;
      thrMode = 1; rxThr = 4'(t);
      step(0,0,0,0,0,1,0,0);
      chk(rxReq == 0, "R7 empty rx no req", rxReq, 0);
      for (int i = 0; i < D; i++) begin
        step(0,0,1,0,0,0,0,rxPat(i,t));
        chk(rxLevel == 5'(i+1), "R2 rx level fill", rxLevel, i+1);
        chk(rxReq == (i+1 >= need), (t > RXMAX) ? "R10 rx clamp" : "R7 rx req",
            rxReq, (i+1 >= need));
      end
      step(0,0,1,0,0,0,0,16'hBEEF);
      chk(rxOverrun == 1 && rxLevel == 5'(D), "R6 overrun on full push", rxOverrun, 1);
      for (int k = 0; k < D; k++) begin
        chk(busRxData == rxPat(k,t), "R4 R2 rx word order", busRxData, rxPat(k,t));
        step(0,0,0,1,0,0,0,0);
        chk(rxReq == (D-k-1 >= need), "R7 rx req drain", rxReq, (D-k-1 >= need));
      end
      chk(busRxData == 0, "R11 empty rx read zero", busRxData, 0);
      step(0,0,0,1,0,0,0,0);
      chk(rxLevel == 0 && rxOverrun == 1, "R11 empty read keeps state", rxLevel, 0);
      chk(rxOverrun == 1, "R6 overrun sticky", rxOverrun, 1);
      step(0,0,0,0,0,1,0,0);
      chk(rxOverrun == 0, "R1 rx clear drops flag", rxOverrun, 0);
    end

    // per-sample mode: thresholds ignored
    thrMode = 0; txThr = 4'd9; rxThr = 4'd9;
    step(0,0,0,0,1,1,0,0);
    step(0,0,1,0,0,0,0,16'h0101);
    chk(rxReq == 1, "R9 rx req on one sample", rxReq, 1);
    for (int i = 0; i < D; i++) step(1,0,0,0,0,0,16'(i),0);
    chk(txReq == 0, "R9 tx req low when full", txReq, 0);
    step(0,1,0,0,0,0,0,0);
    chk(txReq == 1, "R9 tx req with one free", txReq, 1);
    step(0,0,0,1,0,0,0,0);
    chk(rxReq == 0, "R9 rx req low when empty", rxReq, 0);

    // per-direction clear leaves the other side alone
    step(0,0,1,0,0,0,0,16'h0A0A);
    step(0,0,1,0,0,0,0,16'h0B0B);
    step(0,0,0,0,1,0,0,0);
    chk(txLevel == 0 && txEmpty, "R1 tx clear", txLevel, 0);
    chk(rxLevel == 2, "R1 rx kept across tx clear", rxLevel, 2);
    chk(busRxData == 16'h0A0A, "R1 rx head kept", busRxData, 16'h0A0A);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule